// File: doc/BRIEF.md
# I2C Target with Word-Addressed Byte Files

This block is an I2C bus target that responds at a fixed 7-bit address. Bytes that a bus master writes are placed into a circular 64-byte receive file, and bytes that a master reads are taken from a circular 64-byte transmit file. On the processor side both files are seen as sixteen 32-bit words. Byte k of a file sits in word k/4, in byte lane k mod 4, with lane 0 in bits 7:0 (little-endian).

The receive side exposes a free-running 6-bit write pointer. Software keeps a snapshot of this pointer and takes the difference modulo 64 to learn how many bytes have arrived. The transmit side exposes the index of the bit most recently placed on the bus. A single status bit records the end of a master write transaction. The bit is cleared by writing one to it, and it drives the interrupt line when the interrupt is enabled. SCL and SDA are sampled by two-flop synchronisers. START and STOP are seen as SDA edges while SCL is high.

The protocol controller has these states. IDLE: bus free. ADDR: shifting in the address byte. ADDR_ACK: driving the address acknowledge. WR_BYTE: shifting in a data byte. WR_ACK: driving the data acknowledge. RD_BYTE: shifting out a data byte. RD_ACK: watching the master's acknowledge. IGNORE: waiting for the next START or STOP.

The transitions are as follows. A START enters ADDR from any state, and a STOP enters IDLE from any state. ADDR goes to ADDR_ACK on a matching address and to IGNORE otherwise. ADDR_ACK goes to WR_BYTE for a write and to RD_BYTE for a read. WR_BYTE and WR_ACK alternate on each byte. RD_BYTE goes to RD_ACK after eight bits. RD_ACK goes back to RD_BYTE when the master ACKs and to IGNORE when the master NACKs.

Top module: `i2c_word_target`

## Requirements
- R1: The address byte is acknowledged only when its upper seven bits equal 0x50. Bit 0 of the address byte selects read (1) or write (0). For any other address the target leaves SDA released for the rest of the transaction and stores nothing.
- R2: Each data byte of an addressed write is acknowledged on the ninth clock. The byte is stored in the receive file at byte index rx_wptr, which is word rx_wptr[5:2], lane rx_wptr[1:0], bits 8*lane+7:8*lane.
- R3: rx_wptr steps by exactly one for each received byte and wraps from 63 to 0.
- R4: Read bytes are sent MSB first from the transmit file at an internal read pointer. The read pointer advances after each byte, wraps modulo 64, and carries over from one read transaction to the next.
- R5: A master NACK after a read byte ends transmission. SDA stays released until the next START or STOP, and the read pointer has already moved past the NACKed byte.
- R6: tx_bitpos equals byte_index*8 + n. Here n counts 0..7 in transmit order, with 0 being the MSB, for the bit most recently driven.
- R7: int_status is set by a STOP, or by a repeated START, that ends an addressed write transaction. irq equals int_status gated by int_en.
- R8: int_status stays set until a cycle with int_clr high and no new completion. A completion in the same cycle as a clear wins.
- R9: After reset, SDA is released, rx_wptr, tx_bitpos and int_status are zero, and irq is low.
- R10: tx_we writes tx_wdata into transmit word tx_widx. rx_rdata shows receive word rx_ridx without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the pad |
| sda_i | input | 1 | Bus data as seen on the pad |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| tx_we | input | 1 | Transmit word write strobe |
| tx_widx | input | 4 | Transmit word index |
| tx_wdata | input | 32 | Transmit word data |
| rx_ridx | input | 4 | Receive word index |
| rx_rdata | output | 32 | Receive word data |
| rx_wptr | output | 6 | Receive byte write pointer |
| tx_bitpos | output | 9 | Index of last transmitted bit |
| int_en | input | 1 | Interrupt enable |
| int_clr | input | 1 | Write-one clear of int_status |
| int_status | output | 1 | Write-complete status |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except for deliberate START and STOP conditions. They also assume that each SCL level lasts several system clocks, long enough to pass the synchronisers. The bench's bit tasks hold every SCL phase for eight clocks. They place data on SDA only in the low phase, and they build START and STOP with SCL held high. Open-drain behaviour is modelled as the AND of the master's drive with the target's release, so the assertions see the same bus that the target sees.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } i2cw_state_e;
endpackage

// File: rtl/i2cw_sync_det.sv
module i2cw_sync_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_pipe[SYNC_STAGES-1];
            sda_q <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cw_rx_file.sv
module i2cw_rx_file #(
    parameter int FILE_BYTES = 64,
    localparam int WORDS = FILE_BYTES / 4,
    localparam int IDX_W = $clog2(WORDS),
    localparam int PTR_W = $clog2(FILE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] widx,
    input  logic [7:0]       wbyte,
    input  logic [IDX_W-1:0] ridx,
    output logic [31:0]      rdata
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else if (we) begin
            mem[widx[PTR_W-1:2]][{widx[1:0], 3'b000} +: 8] <= wbyte;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/i2cw_tx_file.sv
module i2cw_tx_file #(
    parameter int FILE_BYTES = 64,
    localparam int WORDS = FILE_BYTES / 4,
    localparam int IDX_W = $clog2(WORDS),
    localparam int PTR_W = $clog2(FILE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic [PTR_W-1:0] rptr,
    output logic [7:0]       rbyte
);
    logic [31:0] mem [WORDS];
    logic [31:0] word_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign word_sel = mem[rptr[PTR_W-1:2]];
    assign rbyte    = word_sel[{rptr[1:0], 3'b000} +: 8];
endmodule

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
    import i2cw_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h50,
    parameter int         PTR_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             sda_s,
    input  logic [7:0]       tx_byte,
    output logic             sda_oe,
    output logic             rx_we,
    output logic [PTR_W-1:0] rx_widx,
    output logic [7:0]       rx_byte,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W+2:0] bitpos,
    output logic             wr_done
);
    i2cw_state_e state, state_nx;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg;
    logic [7:0]  txsh;
    logic        rw;
    logic        wr_act;
    logic        addr_hit;

    assign addr_hit = (shreg[7:1] == TARGET_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (scl_fall && bitcnt == 4'd8)
                                 state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)
                                 state_nx = rw ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (scl_fall && bitcnt == 4'd8)
                                 state_nx = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall)
                                 state_nx = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && bitcnt == 4'd7)
                                 state_nx = ST_RD_ACK;
                ST_RD_ACK:   if (scl_rise && sda_s)
                                 state_nx = ST_IGNORE;
                             else if (scl_fall)
                                 state_nx = ST_RD_BYTE;
                ST_IGNORE:   state_nx = ST_IGNORE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt  <= '0;
            shreg   <= '0;
            txsh    <= '0;
            rw      <= 1'b0;
            wr_act  <= 1'b0;
            sda_oe  <= 1'b0;
            rx_we   <= 1'b0;
            rx_widx <= '0;
            rx_byte <= '0;
            wptr    <= '0;
            rd_ptr  <= '0;
            bitpos  <= '0;
            wr_done <= 1'b0;
        end else begin
            rx_we   <= 1'b0;
            wr_done <= 1'b0;
            if (start_det || stop_det) begin
                bitcnt  <= '0;
                shreg   <= '0;
                sda_oe  <= 1'b0;
                wr_done <= wr_act;
                wr_act  <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8 && addr_hit) begin
                            sda_oe <= 1'b1;
                            rw     <= shreg[0];
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (!rw) begin
                                sda_oe <= 1'b0;
                                wr_act <= 1'b1;
                            end else begin
                                sda_oe <= ~tx_byte[7];
                                txsh   <= tx_byte;
                                bitpos <= {rd_ptr, 3'd0};
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            rx_we   <= 1'b1;
                            rx_widx <= wptr;
                            rx_byte <= shreg;
                            wptr    <= wptr + 1'b1;
                            sda_oe  <= 1'b1;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                rd_ptr <= rd_ptr + 1'b1;
                            end else begin
                                bitcnt <= bitcnt + 4'd1;
                                sda_oe <= ~txsh[6];
                                txsh   <= {txsh[6:0], 1'b0};
                                bitpos <= {rd_ptr, 3'(bitcnt[2:0] + 3'd1)};
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_fall && !(scl_rise && sda_s)) begin
                            bitcnt <= '0;
                            sda_oe <= ~tx_byte[7];
                            txsh   <= tx_byte;
                            bitpos <= {rd_ptr, 3'd0};
                        end
                    end
                    ST_IDLE, ST_IGNORE: begin
                        sda_oe <= 1'b0;
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_word_target.sv
module i2c_word_target #(
    parameter logic [6:0] TARGET_ADDR = 7'h50,
    parameter int         FILE_BYTES  = 64,
    parameter int         SYNC_STAGES = 2,
    localparam int WORDS = FILE_BYTES / 4,
    localparam int IDX_W = $clog2(WORDS),
    localparam int PTR_W = $clog2(FILE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             tx_we,
    input  logic [IDX_W-1:0] tx_widx,
    input  logic [31:0]      tx_wdata,
    input  logic [IDX_W-1:0] rx_ridx,
    output logic [31:0]      rx_rdata,
    output logic [PTR_W-1:0] rx_wptr,
    output logic [PTR_W+2:0] tx_bitpos,
    input  logic             int_en,
    input  logic             int_clr,
    output logic             int_status,
    output logic             irq
);
    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]       tx_byte;
    logic             rx_we;
    logic [PTR_W-1:0] rx_widx;
    logic [7:0]       rx_byte;
    logic [PTR_W-1:0] rd_ptr;
    logic             wr_done;

    i2cw_sync_det #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cw_ctrl #(.TARGET_ADDR(TARGET_ADDR), .PTR_W(PTR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
        .tx_byte(tx_byte), .sda_oe(sda_oe), .rx_we(rx_we), .rx_widx(rx_widx),
        .rx_byte(rx_byte), .wptr(rx_wptr), .rd_ptr(rd_ptr), .bitpos(tx_bitpos),
        .wr_done(wr_done)
    );

    i2cw_rx_file #(.FILE_BYTES(FILE_BYTES)) u_rx (
        .clk(clk), .rst_n(rst_n), .we(rx_we), .widx(rx_widx), .wbyte(rx_byte),
        .ridx(rx_ridx), .rdata(rx_rdata)
    );

    i2cw_tx_file #(.FILE_BYTES(FILE_BYTES)) u_tx (
        .clk(clk), .rst_n(rst_n), .we(tx_we), .widx(tx_widx), .wdata(tx_wdata),
        .rptr(rd_ptr), .rbyte(tx_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        int_status <= 1'b0;
        else if (wr_done)  int_status <= 1'b1;
        else if (int_clr)  int_status <= 1'b0;
    end

    assign irq = int_status & int_en;
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker #(
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             start_det,
    input logic             stop_det,
    input logic             sda_oe,
    input logic [PTR_W-1:0] rx_wptr,
    input logic [PTR_W+2:0] tx_bitpos,
    input logic             int_status,
    input logic             int_clr
);
    AST_OE_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!scl_s || $past(start_det || stop_det))); // R5

    AST_WPTR_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wptr != $past(rx_wptr)) |-> (rx_wptr == PTR_W'($past(rx_wptr) + 1'b1))); // R3

    AST_BITPOS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_bitpos) |-> !scl_s); // R6

    AST_STATUS_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_status) |-> $past(start_det || stop_det, 2)); // R7

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (int_status && !int_clr) |=> int_status); // R8
endmodule

bind i2c_word_target i2cw_checker #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
    .stop_det(stop_det), .sda_oe(sda_oe), .rx_wptr(rx_wptr),
    .tx_bitpos(tx_bitpos), .int_status(int_status), .int_clr(int_clr)
);

// File: tb/i2c_word_target_bench.sv
module i2c_word_target_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        tx_we = 1'b0;
    logic [3:0]  tx_widx = '0;
    logic [31:0] tx_wdata = '0;
    logic [3:0]  rx_ridx = '0;
    logic [31:0] rx_rdata;
    logic [5:0]  rx_wptr;
    logic [8:0]  tx_bitpos;
    logic        int_en = 1'b1;
    logic        int_clr = 1'b0;
    logic        int_status;
    logic        irq;
    logic        sda_bus;
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_word_target u_i2c_word_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .tx_we(tx_we), .tx_widx(tx_widx), .tx_wdata(tx_wdata),
        .rx_ridx(rx_ridx), .rx_rdata(rx_rdata), .rx_wptr(rx_wptr),
        .tx_bitpos(tx_bitpos), .int_en(int_en), .int_clr(int_clr),
        .int_status(int_status), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic q();
        repeat (8) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
    endtask

    task automatic bus_bit(input logic b, output logic r);
        sda_m = b; q(); scl_m = 1'b1; q(); r = sda_bus; q(); scl_m = 1'b0; q();
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(v[i], r);
        bus_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r);
            v[i] = r;
        end
        bus_bit(nack, r);
    endtask

    task automatic pulse_clr();
        @(negedge clk); int_clr = 1'b1; @(negedge clk); int_clr = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset();
        check(sda_oe == 1'b0, "R9 sda_oe", 32'(sda_oe), 0);
        check(rx_wptr == 6'd0, "R9 rx_wptr", 32'(rx_wptr), 0);
        check(tx_bitpos == 9'd0, "R9 tx_bitpos", 32'(tx_bitpos), 0);
        check(int_status == 1'b0 && irq == 1'b0, "R9 status/irq", {int_status, irq}, 0);
    endtask

    task automatic t_write3();
        logic a;
        bus_start();
        put_byte(8'hA0, a); check(a, "R1 addr ack", 32'(a), 1);
        put_byte(8'h11, a); check(a, "R2 data ack", 32'(a), 1);
        put_byte(8'h22, a);
        put_byte(8'h33, a); check(a, "R2 data ack 3", 32'(a), 1);
        bus_stop(); q();
        check(rx_wptr == 6'd3, "R3 wptr after 3", 32'(rx_wptr), 3);
        rx_ridx = 4'd0; @(negedge clk);
        check(rx_rdata[23:0] == 24'h332211, "R2 R10 word0 lanes", rx_rdata[23:0], 32'h332211);
        check(int_status && irq, "R7 status on stop", {int_status, irq}, 3);
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start();
        put_byte(8'hA4, a); check(!a, "R1 foreign addr nack", 32'(a), 0);
        put_byte(8'h77, a); check(!a, "R1 foreign data nack", 32'(a), 0);
        bus_stop(); q();
        check(rx_wptr == 6'd3, "R1 wptr unchanged", 32'(rx_wptr), 3);
    endtask

    task automatic t_status();
        int_en = 1'b0; @(negedge clk);
        check(int_status && !irq, "R7 irq gated", {int_status, irq}, 2);
        check(int_status, "R8 sticky", 32'(int_status), 1);
        pulse_clr();
        check(!int_status, "R8 w1c", 32'(int_status), 0);
        int_en = 1'b1;
    endtask

    task automatic t_read();
        logic [7:0] v;
        @(negedge clk); tx_we = 1'b1; tx_widx = 4'd0; tx_wdata = 32'h44332211;
        @(negedge clk); tx_widx = 4'd1; tx_wdata = 32'h88776655;
        @(negedge clk); tx_we = 1'b0;
        bus_start();
        put_byte(8'hA1, v[0]);
        get_byte(1'b0, v); check(v == 8'h11, "R4 read b0", v, 8'h11);
        get_byte(1'b0, v); check(v == 8'h22, "R4 read b1", v, 8'h22);
        get_byte(1'b0, v);
        get_byte(1'b1, v); check(v == 8'h44, "R4 read b3", v, 8'h44);
        check(sda_oe == 1'b0, "R5 released after nack", 32'(sda_oe), 0);
        check(tx_bitpos == 9'd31, "R6 bitpos", 32'(tx_bitpos), 31);
        bus_stop(); q();
        check(!int_status, "R7 no status on read", 32'(int_status), 0);
        bus_start();
        put_byte(8'hA1, v[0]);
        get_byte(1'b1, v); check(v == 8'h55, "R4 R5 pointer carries", v, 8'h55);
        check(tx_bitpos == 9'd39, "R6 bitpos second", 32'(tx_bitpos), 39);
        bus_stop(); q();
    endtask

    task automatic t_restart();
        logic       a;
        logic [7:0] v;
        bus_start();
        put_byte(8'hA0, a);
        put_byte(8'h5A, a);
        bus_start(); q();
        check(int_status, "R7 status on repeated start", 32'(int_status), 1);
        put_byte(8'hA1, a);
        get_byte(1'b1, v); check(v == 8'h66, "R4 read after restart", v, 8'h66);
        bus_stop(); q();
        check(rx_wptr == 6'd4, "R3 wptr 4", 32'(rx_wptr), 4);
        rx_ridx = 4'd0; @(negedge clk);
        check(rx_rdata[31:24] == 8'h5A, "R2 lane3", rx_rdata[31:24], 8'h5A);
        pulse_clr();
    endtask

    task automatic t_wrap();
        logic a;
        bus_start();
        put_byte(8'hA0, a);
        for (int k = 0; k < 61; k++) put_byte(8'(8'h80 + k), a);
        bus_stop(); q();
        check(rx_wptr == 6'd1, "R3 wptr wrap", 32'(rx_wptr), 1);
        rx_ridx = 4'd15; @(negedge clk);
        check(rx_rdata[31:24] == 8'hBB, "R2 byte 63", rx_rdata[31:24], 8'hBB);
        rx_ridx = 4'd0; @(negedge clk);
        check(rx_rdata[7:0] == 8'hBC, "R3 wrap overwrite", rx_rdata[7:0], 8'hBC);
        check(int_status, "R7 status after long write", 32'(int_status), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_write3();
        t_wrong_addr();
        t_status();
        t_read();
        t_restart();
        t_wrap();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule